// File: doc/BRIEF.md
# Expansion-board configuration responder

This block lets a host discover and place an expansion board that is still unconfigured. Until the host has finished with it, the block answers reads from a 128-byte configuration window. Each logical configuration byte is spread over two window locations, one nibble in each, and most nibbles are stored inverted. The host then writes a base address, which maps the board, or a shut-up command, which leaves it unmapped. After either write the block raises a done signal so that the next board in a daisy chain can start its own configuration.

Once a base address is in place, the block decodes full host addresses into a single board-select. Only the address bits above the 16 MiB window take part in that compare. The logical configuration bytes come from a flat table input. Logical byte 9 is overridden by a code derived from a 3-bit strap, so a board can report a size or option setting without changing its table.

Top module: `autocfg_responder`

## Requirements
- R1: After reset, `configured`, `cfg_done` and `board_sel` are 0 and `base_addr` is 0.
- R2: While unconfigured, reading window offset 4k returns the upper nibble of logical byte k in bits 7:4, and reading offset 4k+2 returns its lower nibble in bits 7:4. Bits 3:0 are 0 before inversion, and all 8 bits are then inverted.
- R3: At offsets 0x00, 0x02, 0x40 and 0x42, the nibble value is returned without inversion.
- R4: Odd offsets, and slots k with no table entry, read as 0xFF.
- R5: While unconfigured, only the low 16 address bits are decoded. An offset of 128 or more reads as 0.
- R6: Logical byte 9 reads as 1 when `strap` is 0, and otherwise as `strap` shifted left by one bit. The table entry for byte 9 is ignored.
- R7: A byte write to offset 0x48 while unconfigured loads `base_addr[15:8]` from `wdata[7:0]` on the next edge and leaves the board unconfigured.
- R8: A word write to offset 0x44 while unconfigured sets `base_addr[31:16]` to `wdata` and raises `configured` and `cfg_done` on the next edge. A byte write to 0x44 changes nothing.
- R9: A byte write to offset 0x4C while unconfigured raises `configured` and `cfg_done`, but the board is never selected afterwards.
- R10: After a base write, `board_sel` is 1 exactly when `req_valid` is 1 and `req_addr[31:24]` equals `base_addr[31:24]`.
- R11: `configured` and `cfg_done` stay high until reset. Writes made after configuration leave `base_addr` unchanged. `rd_data` is 0 while configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 16 | Write data (a byte write uses bits 7:0) |
| cfg_table | input | 256 | Logical configuration bytes; byte k is in bits 8k+7:8k |
| strap | input | 3 | Option strap that overrides logical byte 9 |
| rd_data | output | 8 | Window read data for `req_addr` |
| configured | output | 1 | Board has left configuration mode |
| board_sel | output | 1 | Access hits the mapped board |
| base_addr | output | 32 | Assigned base address |
| cfg_done | output | 1 | Chain enable for the next board |

## Verification
Some properties are checked by assertions on every cycle. `configured` and `cfg_done` never fall. The base address stays frozen once the board is configured. A qualifying base write or shut-up write produces the matching state on the next edge. `board_sel` never rises on a board that has not been configured.

The nibble split and the inversion pattern can only be shown by the bench's read scenarios. The same holds for the strap override, the 16-bit address fold and the 0 above the window. Those scenarios run against randomized tables and straps. The bench scenarios are also the only place where two things are shown: the compare over bits 31:24 only, and the rule that a shut-up leaves the board unselectable.

// File: rtl/acr_pkg.sv
// Shared constants, command encoding and the strap-code helper for the
// configuration responder. Assumes byte offsets within a 16-bit window.
package acr_pkg;
    localparam int STRAP_W    = 3;
    localparam int STRAP_SLOT = 9;
    localparam logic [15:0] OFF_BASE_HI = 16'h0044;
    localparam logic [15:0] OFF_BASE_LO = 16'h0048;
    localparam logic [15:0] OFF_SHUTUP  = 16'h004C;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_BASE_HI,
        CMD_BASE_LO,
        CMD_SHUTUP
    } cfg_cmd_e;

    // Code reported in logical byte 9 for a given strap setting.
    function automatic logic [7:0] strap_code(input logic [STRAP_W-1:0] s);
        logic [7:0] r;
        r = '0;
        if (s == '0) r = 8'd1;
        else         r[STRAP_W:1] = s;
        return r;
    endfunction
endpackage

// File: rtl/acr_window_view.sv
// Combinational view of the configuration window. Each logical byte is
// split into two nibble locations, and the nibbles are inverted except in
// the two descriptor slots. Assumes CFG_BYTES <= SPACE_BYTES/4.
module acr_window_view
    import acr_pkg::*;
#(
    parameter int CFG_BYTES   = 32,
    parameter int SPACE_BYTES = 128
) (
    input  logic [15:0]            off,
    input  logic [CFG_BYTES*8-1:0] table_i,
    input  logic [STRAP_W-1:0]     strap,
    output logic [7:0]             data
);
    localparam int SLOTS  = SPACE_BYTES / 4;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int OFF_W  = $clog2(SPACE_BYTES);
    localparam logic [SLOT_W-1:0] TRUE_SLOT_HI = SLOT_W'(SPACE_BYTES / 8);

    logic [7:0]       slot_byte [SLOTS];
    logic [SLOTS-1:0] slot_filled;

    // Build the logical byte of each slot, with the strap override.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k == STRAP_SLOT && k < CFG_BYTES) begin : g_strap
            assign slot_byte[k]   = strap_code(strap);
            assign slot_filled[k] = 1'b1;
        end else if (k < CFG_BYTES) begin : g_tab
            assign slot_byte[k]   = table_i[8*k +: 8];
            assign slot_filled[k] = 1'b1;
        end else begin : g_empty
            assign slot_byte[k]   = 8'hFF;
            assign slot_filled[k] = 1'b0;
        end
    end

    logic [SLOT_W-1:0] idx;
    logic [7:0]        raw;

    assign idx = off[OFF_W-1:2];

    // Select the nibble, then apply the per-slot inversion rule.
    always_comb begin
        raw = off[1] ? {slot_byte[idx][3:0], 4'h0} : {slot_byte[idx][7:4], 4'h0};
        if (off >= 16'(SPACE_BYTES))
            data = 8'h00;
        else if (off[0] || !slot_filled[idx])
            data = 8'hFF;
        else if (idx == '0 || idx == TRUE_SLOT_HI)
            data = raw;
        else
            data = ~raw;
    end
endmodule

// File: rtl/acr_cfg_ctrl.sv
// Decodes the host's configuration writes and holds the configuration
// state. Writes are honoured only while unconfigured. Assumes a single
// access per cycle, qualified by req_valid.
module acr_cfg_ctrl
    import acr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [15:0]       off,
    input  logic [15:0]       wdata,
    output logic              configured,
    output logic              mapped,
    output logic [ADDR_W-1:0] base_addr,
    output logic              cfg_done
);
    cfg_cmd_e cmd;

    // Classify the current access into a configuration command.
    always_comb begin
        cmd = CMD_NONE;
        if (req_valid && req_write && !configured) begin
            if (req_word && off == OFF_BASE_HI)       cmd = CMD_BASE_HI;
            else if (!req_word && off == OFF_BASE_LO) cmd = CMD_BASE_LO;
            else if (!req_word && off == OFF_SHUTUP)  cmd = CMD_SHUTUP;
        end
    end

    // Update base and state flags on accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            configured <= 1'b0;
            mapped     <= 1'b0;
            cfg_done   <= 1'b0;
            base_addr  <= '0;
        end else begin
            case (cmd)
                CMD_BASE_HI: begin
                    base_addr[ADDR_W-1 -: 16] <= wdata;
                    configured <= 1'b1;
                    mapped     <= 1'b1;
                    cfg_done   <= 1'b1;
                end
                CMD_BASE_LO: base_addr[15:8] <= wdata[7:0];
                CMD_SHUTUP: begin
                    configured <= 1'b1;
                    cfg_done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cfg_done));
    assert_cfg_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(configured));
    assert_base_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> $stable(base_addr));
    assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_word && !configured && off == OFF_BASE_HI)
        |=> (configured && cfg_done && base_addr[ADDR_W-1 -: 16] == $past(wdata)));
    assert_shutup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_word && !configured && off == OFF_SHUTUP)
        |=> (configured && cfg_done && !mapped));
endmodule

// File: rtl/acr_sel_match.sv
// Board-select compare on the address bits above the mapped window.
// Assumes that selection is only meaningful once a base has been written.
module acr_sel_match #(
    parameter int ADDR_W    = 32,
    parameter int MATCH_LSB = 24
) (
    input  logic              req_valid,
    input  logic              mapped,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              board_sel
);
    localparam int HI_W = ADDR_W - MATCH_LSB;

    // Compare the upper address field against the base.
    always_comb begin
        board_sel = req_valid && mapped &&
                    (req_addr[ADDR_W-1 -: HI_W] == base_addr[ADDR_W-1 -: HI_W]);
    end
endmodule

// File: rtl/autocfg_responder.sv
// Top of the configuration responder. It exposes the nibble window while
// the board is unconfigured, accepts the base and shut-up writes, and
// selects the board afterwards. Assumes ADDR_W >= 32.
module autocfg_responder
    import acr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CFG_BYTES   = 32,
    parameter int SPACE_BYTES = 128,
    parameter int MATCH_LSB   = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_word,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [15:0]            req_wdata,
    input  logic [CFG_BYTES*8-1:0] cfg_table,
    input  logic [STRAP_W-1:0]     strap,
    output logic [7:0]             rd_data,
    output logic                   configured,
    output logic                   board_sel,
    output logic [ADDR_W-1:0]      base_addr,
    output logic                   cfg_done
);
    logic [15:0] off;
    logic [7:0]  view_data;
    logic        mapped;

    assign off = req_addr[15:0];

    acr_window_view #(.CFG_BYTES(CFG_BYTES), .SPACE_BYTES(SPACE_BYTES)) u_view (
        .off(off), .table_i(cfg_table), .strap(strap), .data(view_data)
    );

    acr_cfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .off(off), .wdata(req_wdata),
        .configured(configured), .mapped(mapped), .base_addr(base_addr),
        .cfg_done(cfg_done)
    );

    acr_sel_match #(.ADDR_W(ADDR_W), .MATCH_LSB(MATCH_LSB)) u_match (
        .req_valid(req_valid), .mapped(mapped), .req_addr(req_addr),
        .base_addr(base_addr), .board_sel(board_sel)
    );

    // The window is visible only before configuration.
    assign rd_data = configured ? 8'h00 : view_data;

    assert_sel_needs_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        board_sel |-> configured);
    assert_done_with_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> configured);
endmodule

// File: tb/test_autocfg_responder.sv
module test_autocfg_responder;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [NB*8-1:0] cfg_table = '0;
    logic [2:0]    strap = '0;
    logic [7:0]    rd_data;
    logic          configured, board_sel, cfg_done;
    logic [31:0]   base_addr;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    autocfg_responder i_autocfg_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_table(cfg_table), .strap(strap), .rd_data(rd_data),
        .configured(configured), .board_sel(board_sel), .base_addr(base_addr),
        .cfg_done(cfg_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [31:0] a, input logic cfgd);
        logic [15:0] o;
        int k;
        logic [7:0] b, raw;
        o = a[15:0];
        if (cfgd) return 8'h00;
        if (o >= 16'd128) return 8'h00;
        if (o[0]) return 8'hFF;
        k = int'(o[6:2]);
        if (k >= NB) return 8'hFF;
        if (k == 9) b = (strap == 0) ? 8'd1 : {4'b0, strap, 1'b0};
        else b = cfg_table[8*k +: 8];
        raw = o[1] ? {b[3:0], 4'h0} : {b[7:4], 4'h0};
        return (k == 0 || k == 16) ? raw : ~raw;
    endfunction

    task automatic rd(input string req, input logic [31:0] a, input logic cfgd);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = a;
        #1 chk(req, {24'h0, rd_data}, {24'h0, exp_read(a, cfgd)});
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic word, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = word; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sel(input string req, input logic [31:0] a, input logic v, input logic exp);
        @(negedge clk);
        req_valid = v; req_write = 1'b0; req_addr = a;
        #1 chk(req, {31'h0, board_sel}, {31'h0, exp});
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        #1;
        chk("R1 configured", {31'h0, configured}, 0);
        chk("R1 cfg_done", {31'h0, cfg_done}, 0);
        chk("R1 board_sel", {31'h0, board_sel}, 0);
        chk("R1 base", base_addr, 0);

        // R2 R4 R5: random tables, straps and addresses
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < NB; w++) cfg_table[8*w +: 8] = 8'($urandom);
            strap = 3'($urandom);
            for (int i = 0; i < 60; i++) begin
                logic [31:0] a;
                a = $urandom;
                if (i % 3 != 0) a[15:0] = 16'($urandom % 128);
                rd("R2 random read", a, 1'b0);
            end
        end

        // R3 true slots
        cfg_table[7:0] = 8'hA5; cfg_table[8*16 +: 8] = 8'h3C;
        rd("R3 off00", 32'h0, 0); rd("R3 off02", 32'h2, 0);
        rd("R3 off40", 32'h40, 0); rd("R3 off42", 32'h42, 0);
        // R2 inverted slot
        cfg_table[8*1 +: 8] = 8'h96;
        rd("R2 off04", 32'h4, 0); rd("R2 off06", 32'h6, 0);
        // R4 odd / filler
        rd("R4 odd", 32'h5, 0); rd("R4 odd7f", 32'h7F, 0);
        // R5 fold and above-window
        rd("R5 above", 32'h80, 0); rd("R5 ffff", 32'h0000FFFF, 0);
        rd("R5 fold", 32'hABCD0004, 0);
        // R6 strap
        cfg_table[8*9 +: 8] = 8'hEE;
        strap = 0; rd("R6 strap0 hi", 32'h24, 0); rd("R6 strap0 lo", 32'h26, 0);
        strap = 5; rd("R6 strap5 hi", 32'h24, 0); rd("R6 strap5 lo", 32'h26, 0);
        strap = 7; rd("R6 strap7 lo", 32'h26, 0);

        // R8: a byte write at the base-high offset does nothing
        wr(32'h44, 1'b0, 16'h00FF);
        chk("R8 byte44 ignored", {31'h0, configured}, 0);
        // R7
        wr(32'h48, 1'b0, 16'h005A);
        chk("R7 lo byte", {24'h0, base_addr[15:8]}, 32'h5A);
        chk("R7 still unconfigured", {31'h0, configured}, 0);
        // R8 base write through the folded address
        wr(32'h00010044, 1'b1, 16'hC300);
        chk("R8 base hi", {16'h0, base_addr[31:16]}, 32'hC300);
        chk("R8 configured", {31'h0, configured}, 1);
        chk("R8 cfg_done", {31'h0, cfg_done}, 1);
        // R10
        sel("R10 hit", 32'hC3123456, 1, 1);
        sel("R10 hit low", 32'hC3000000, 1, 1);
        sel("R10 miss", 32'hC4000000, 1, 0);
        sel("R10 miss2", 32'hC2FFFFFF, 1, 0);
        sel("R10 no valid", 32'hC3000000, 0, 0);
        // R11
        rd("R11 rd zero", 32'h0, 1);
        wr(32'h44, 1'b1, 16'h1111);
        wr(32'h48, 1'b0, 16'h0011);
        chk("R11 base frozen", base_addr, 32'hC3005A00);
        chk("R11 cfg_done kept", {31'h0, cfg_done}, 1);

        // R9 shut-up path
        do_reset();
        #1 chk("R1 done cleared", {31'h0, cfg_done}, 0);
        wr(32'h4C, 1'b0, 16'h0000);
        chk("R9 configured", {31'h0, configured}, 1);
        chk("R9 cfg_done", {31'h0, cfg_done}, 1);
        sel("R9 never selected", 32'h00000000, 1, 0);
        wr(32'h44, 1'b1, 16'h0000);
        sel("R9 base write ignored", 32'h00001234, 1, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule